// File: doc/BRIEF.md
# Three-Wire Synthesizer Control Word Loader

This block receives 24-bit control words over a three-wire serial link (serial clock, serial data, strobe) and distributes each word to one of four register groups: the main divider group, the reference/compensation group, the auxiliary/charge-pump/lock/enable group, and the transmit-control group. All three serial lines are sampled in the system clock domain. While the strobe is low, each rising serial clock shifts one data bit in; bits arrive least significant first, so the last bit shifted sits in bit 23, where the address lives. The rising strobe edge transfers the word to the group that its address selects.

Changes to the main divider ratio must not disturb the loop's phase. A received main-divider word is therefore held pending and reaches the working registers only on a divider synchronization pulse. The compensation DAC value of the reference word is held in a temporary register and joins the working set in that same commit. When a main-divider word commits while the strobe is still high, a speed-up flag is raised and kept until the strobe falls. A one-cycle load pulse per group tells downstream logic when each group's outputs have changed.

Top module: `synth_prog_if`

## Requirements
- R1: A synchronous active-high reset sets nmain=1000, nf=0, fmod=0, fdac=80 (working and temporary), nref=81, rsm=0, rsa=0, naux=458, cp_sel=0, lock_sel=0, main_en=0, aux_en=0, every transmit-control field to 0, speedup=0 and word_ld=0.
- R2: While the sampled strobe is low, each sampled rising edge of ser_clk shifts ser_dat into a 24-bit register from the top downward, so the first bit sent ends in bit 0 and the last bit sent in bit 23.
- R3: While the strobe is high, serial clock edges leave the shift register unchanged; a later strobe rise without new bits reloads the same word.
- R4: Address decode on bits [23:22]: 00 selects the main-divider word, 01 the reference word, 10 the auxiliary word; bits [23:21]=110 select the transmit word; 111 loads nothing.
- R5: On a strobe rise, reference, auxiliary and transmit words update their outputs at once. Reference: nref=[21:12], rsm=[11:10], rsa=[9:8], DAC value=[7:0]. Auxiliary: naux=[21:8], cp_sel=[7:6], lock_sel=[5:4], main_en=[3], aux_en=[2]. Transmit: pwr_att=[20:13], mdiv_sel=[12:11], offset_en=[10], tx_mode=[9], dig_mode=[8], txlo_buf_en=[7], rclk_buf_en=[6], pa_test=[5:0].
- R6: A main-divider word (fmod=[21], nf=[20:18], nmain=[17:2]) is held pending and reaches fmod/nf/nmain only on a div_sync pulse; div_sync with nothing pending changes nothing.
- R7: The DAC value of a reference word goes to a temporary register; the fdac output takes it only when a main-divider word commits.
- R8: A main-divider word received while another is pending replaces it.
- R9: speedup rises with a main-divider commit that happens while the strobe is high and falls after the strobe goes low; a commit with the strobe low leaves speedup at 0.
- R10: Each strobe high period causes at most one load; word_ld bit 0 pulses for one cycle on a main-divider commit, bits 1, 2, 3 on reference, auxiliary and transmit loads.
- R11: When a main-divider load and div_sync fall in the same cycle, the previously pending word commits and the new one becomes pending.
- R12: At most one word_ld bit is high in any cycle from strobe-driven loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, LSB first |
| ser_stb | input | 1 | Strobe: low shifts, rising edge loads |
| div_sync | input | 1 | Main divider terminal-count pulse |
| fmod | output | 1 | Fractional modulus select (working) |
| nf | output | 3 | Fractional increment (working) |
| nmain | output | 16 | Main divider ratio (working) |
| fdac | output | 8 | Compensation DAC value (working) |
| speedup | output | 1 | Charge pump speed-up flag |
| nref | output | 10 | Reference divider ratio |
| rsm | output | 2 | Main comparison tap select |
| rsa | output | 2 | Auxiliary comparison tap select |
| naux | output | 14 | Auxiliary divider ratio |
| cp_sel | output | 2 | Charge pump current ratio |
| lock_sel | output | 2 | Lock output source select |
| main_en | output | 1 | Main loop enable |
| aux_en | output | 1 | Auxiliary loop enable |
| pwr_att | output | 8 | Transmit attenuation code |
| mdiv_sel | output | 2 | Offset divider select |
| offset_en | output | 1 | Offset loop enable |
| tx_mode | output | 1 | Transmit mode bit |
| dig_mode | output | 1 | Digital/analog modulation select |
| txlo_buf_en | output | 1 | Transmit LO buffer enable |
| rclk_buf_en | output | 1 | Reference clock buffer enable |
| pa_test | output | 6 | Amplifier test current code |
| word_ld | output | 4 | Per-group load pulses (A, B, C, D) |

## Verification
The arrival of a new main-divider word and the divider synchronization pulse can land in the same cycle, as can a commit and the strobe still being high. The bench times div_sync to coincide with the cycle in which a second main-divider word is decoded and judges that the word pending before it committed while the new one waits for the next pulse. It also commits with the strobe high and with it low and judges the speed-up flag in each case.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int WORD_W    = 24;
  localparam int NUM_WORDS = 4;
  localparam int NMAIN_W   = 16;
  localparam int NF_W      = 3;
  localparam int NREF_W    = 10;
  localparam int SEL_W     = 2;
  localparam int FDAC_W    = 8;
  localparam int NAUX_W    = 14;
  localparam int PWR_W     = 8;
  localparam int TEST_W    = 6;

  typedef enum logic [1:0] {W_A = 2'd0, W_B = 2'd1, W_C = 2'd2, W_D = 2'd3} word_e;

  localparam logic [1:0] CODE_A = 2'b00;
  localparam logic [1:0] CODE_B = 2'b01;
  localparam logic [1:0] CODE_C = 2'b10;
  localparam logic [2:0] CODE_D = 3'b110;

  typedef struct packed {
    logic              fmod;
    logic [NF_W-1:0]   nf;
    logic [NMAIN_W-1:0] nmain;
  } a_fields_t;

  typedef struct packed {
    logic [NREF_W-1:0] nref;
    logic [SEL_W-1:0]  rsm;
    logic [SEL_W-1:0]  rsa;
    logic [FDAC_W-1:0] fdac;
  } b_fields_t;

  typedef struct packed {
    logic [NAUX_W-1:0] naux;
    logic [SEL_W-1:0]  cp;
    logic [SEL_W-1:0]  lock_sel;
    logic              main_en;
    logic              aux_en;
  } c_fields_t;

  typedef struct packed {
    logic [PWR_W-1:0]  pwr;
    logic [SEL_W-1:0]  mdiv;
    logic              offset_en;
    logic              tm;
    logic              ad;
    logic              txlo_en;
    logic              rclk_en;
    logic [TEST_W-1:0] test;
  } d_fields_t;

  localparam int A_W = $bits(a_fields_t);
  localparam int B_W = $bits(b_fields_t);
  localparam int C_W = $bits(c_fields_t);
  localparam int D_W = $bits(d_fields_t);

  localparam a_fields_t A_DEF = '{fmod: 1'b0, nf: '0, nmain: 16'd1000};
  localparam b_fields_t B_DEF = '{nref: 10'd81, rsm: '0, rsa: '0, fdac: 8'd80};
  localparam c_fields_t C_DEF = '{naux: 14'd458, cp: '0, lock_sel: '0,
                                  main_en: 1'b0, aux_en: 1'b0};
  localparam d_fields_t D_DEF = '0;

  function automatic a_fields_t get_a(input logic [WORD_W-1:0] w);
    return a_fields_t'(w[WORD_W-3 -: A_W]);
  endfunction
  function automatic b_fields_t get_b(input logic [WORD_W-1:0] w);
    return b_fields_t'(w[WORD_W-3 -: B_W]);
  endfunction
  function automatic c_fields_t get_c(input logic [WORD_W-1:0] w);
    return c_fields_t'(w[WORD_W-3 -: C_W]);
  endfunction
  function automatic d_fields_t get_d(input logic [WORD_W-1:0] w);
    return d_fields_t'(w[WORD_W-4 -: D_W]);
  endfunction
endpackage

// File: rtl/synth_prog_shifter.sv
module synth_prog_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_clk,
  input  logic         ser_dat,
  input  logic         ser_stb,
  output logic [W-1:0] shreg,
  output logic         stb_rise,
  output logic         stb_high
);
  logic sclk_q, sclk_d, dat_q, stb_q, stb_d;
  logic shift_en;

  assign shift_en = sclk_q & ~sclk_d & ~stb_q;
  assign stb_rise = stb_q & ~stb_d;
  assign stb_high = stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      sclk_d <= 1'b0;
      dat_q  <= 1'b0;
      stb_q  <= 1'b0;
      stb_d  <= 1'b0;
      shreg  <= '0;
    end else begin
      sclk_q <= ser_clk;
      sclk_d <= sclk_q;
      dat_q  <= ser_dat;
      stb_q  <= ser_stb;
      stb_d  <= stb_q;
      if (shift_en) shreg <= {dat_q, shreg[W-1:1]};
    end
  end

  // R3
  hold_while_high_chk: assert property (@(posedge clk) disable iff (rst)
    stb_q |=> $stable(shreg));
  // R2
  shift_lsb_first_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (shreg[W-1] == $past(dat_q)) && (shreg[W-2:0] == $past(shreg[W-1:1])));
endmodule

// File: rtl/synth_prog_decoder.sv
module synth_prog_decoder
  import synth_prog_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NW = NUM_WORDS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  word,
  input  logic          stb_rise,
  output logic [NW-1:0] hit_q,
  output logic [W-1:0]  word_q
);
  logic [NW-1:0] hit;

  always_comb begin
    hit = '0;
    if (stb_rise) begin
      if (word[W-1 -: 2] == CODE_A)      hit[W_A] = 1'b1;
      else if (word[W-1 -: 2] == CODE_B) hit[W_B] = 1'b1;
      else if (word[W-1 -: 2] == CODE_C) hit[W_C] = 1'b1;
      else if (word[W-1 -: 3] == CODE_D) hit[W_D] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= '0;
      word_q <= '0;
    end else begin
      hit_q <= hit;
      if (stb_rise) word_q <= word;
    end
  end

  // R12
  single_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_q));
  // R10
  one_load_per_high_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_q != '0) |=> (hit_q == '0));
  // R4
  invalid_code_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_rise && word[W-1 -: 3] == 3'b111) |=> (hit_q == '0));
endmodule

// File: rtl/synth_prog_astage.sv
module synth_prog_astage
  import synth_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_a,
  input  a_fields_t         a_in,
  input  logic              ld_b,
  input  logic [FDAC_W-1:0] fdac_in,
  input  logic              div_sync,
  input  logic              stb_high,
  output a_fields_t         a_work,
  output logic [FDAC_W-1:0] fdac_work,
  output logic              speedup,
  output logic              commit
);
  a_fields_t         pend_a;
  logic              pend_v;
  logic [FDAC_W-1:0] fdac_tmp;
  logic              commit_now;

  assign commit_now = div_sync & pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_work    <= A_DEF;
      pend_a    <= A_DEF;
      pend_v    <= 1'b0;
      fdac_tmp  <= B_DEF.fdac;
      fdac_work <= B_DEF.fdac;
      speedup   <= 1'b0;
      commit    <= 1'b0;
    end else begin
      if (commit_now) begin
        a_work    <= pend_a;
        fdac_work <= fdac_tmp;
      end
      if (ld_a) begin
        pend_a <= a_in;
        pend_v <= 1'b1;
      end else if (commit_now) begin
        pend_v <= 1'b0;
      end
      if (ld_b) fdac_tmp <= fdac_in;
      speedup <= stb_high & (speedup | commit_now);
      commit  <= commit_now;
    end
  end

  // R6
  commit_on_sync_chk: assert property (@(posedge clk) disable iff (rst)
    !div_sync |=> ($stable(a_work) && $stable(fdac_work)));
  // R8
  pending_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_v && !div_sync && !ld_a) |=> (pend_v && $stable(pend_a)));
  // R11
  load_and_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_a && commit_now) |=> (pend_v && a_work == $past(pend_a)));
  // R9
  speedup_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !stb_high |=> !speedup);
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk,
  input  logic               ser_dat,
  input  logic               ser_stb,
  input  logic               div_sync,
  output logic               fmod,
  output logic [NF_W-1:0]    nf,
  output logic [NMAIN_W-1:0] nmain,
  output logic [FDAC_W-1:0]  fdac,
  output logic               speedup,
  output logic [NREF_W-1:0]  nref,
  output logic [SEL_W-1:0]   rsm,
  output logic [SEL_W-1:0]   rsa,
  output logic [NAUX_W-1:0]  naux,
  output logic [SEL_W-1:0]   cp_sel,
  output logic [SEL_W-1:0]   lock_sel,
  output logic               main_en,
  output logic               aux_en,
  output logic [PWR_W-1:0]   pwr_att,
  output logic [SEL_W-1:0]   mdiv_sel,
  output logic               offset_en,
  output logic               tx_mode,
  output logic               dig_mode,
  output logic               txlo_buf_en,
  output logic               rclk_buf_en,
  output logic [TEST_W-1:0]  pa_test,
  output logic [NUM_WORDS-1:0] word_ld
);
  logic [WORD_W-1:0]    shreg, word_q;
  logic                 stb_rise, stb_high;
  logic [NUM_WORDS-1:0] hit_q;
  logic [NUM_WORDS-1:1] grp_ld;
  a_fields_t            a_work;
  b_fields_t            b_q, b_in;
  c_fields_t            c_q;
  d_fields_t            d_q;
  logic                 a_commit;

  synth_prog_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb),
    .shreg(shreg), .stb_rise(stb_rise), .stb_high(stb_high));

  synth_prog_decoder #(.W(WORD_W), .NW(NUM_WORDS)) u_dec (
    .clk(clk), .rst(rst), .word(shreg), .stb_rise(stb_rise),
    .hit_q(hit_q), .word_q(word_q));

  assign b_in = get_b(word_q);

  synth_prog_astage u_astage (
    .clk(clk), .rst(rst),
    .ld_a(hit_q[W_A]), .a_in(get_a(word_q)),
    .ld_b(hit_q[W_B]), .fdac_in(b_in.fdac),
    .div_sync(div_sync), .stb_high(stb_high),
    .a_work(a_work), .fdac_work(fdac), .speedup(speedup), .commit(a_commit));

  always_ff @(posedge clk) begin
    if (rst) begin
      b_q    <= B_DEF;
      c_q    <= C_DEF;
      d_q    <= D_DEF;
      grp_ld <= '0;
    end else begin
      if (hit_q[W_B]) b_q <= b_in;
      if (hit_q[W_C]) c_q <= get_c(word_q);
      if (hit_q[W_D]) d_q <= get_d(word_q);
      grp_ld <= hit_q[NUM_WORDS-1:1];
    end
  end

  assign word_ld     = {grp_ld, a_commit};
  assign fmod        = a_work.fmod;
  assign nf          = a_work.nf;
  assign nmain       = a_work.nmain;
  assign nref        = b_q.nref;
  assign rsm         = b_q.rsm;
  assign rsa         = b_q.rsa;
  assign naux        = c_q.naux;
  assign cp_sel      = c_q.cp;
  assign lock_sel    = c_q.lock_sel;
  assign main_en     = c_q.main_en;
  assign aux_en      = c_q.aux_en;
  assign pwr_att     = d_q.pwr;
  assign mdiv_sel    = d_q.mdiv;
  assign offset_en   = d_q.offset_en;
  assign tx_mode     = d_q.tm;
  assign dig_mode    = d_q.ad;
  assign txlo_buf_en = d_q.txlo_en;
  assign rclk_buf_en = d_q.rclk_en;
  assign pa_test     = d_q.test;

  // R5
  d_group_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_q[W_D] |=> $stable(d_q));
  // R5
  c_group_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_q[W_C] |=> $stable(c_q));
  // R10
  ld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (grp_ld != '0) |=> (grp_ld == '0));
endmodule

// File: tb/tb_synth_prog_if.sv
module tb_synth_prog_if;
  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_stb = 1'b0, div_sync = 1'b0;
  logic fmod, speedup, main_en, aux_en, offset_en, tx_mode, dig_mode, txlo_buf_en, rclk_buf_en;
  logic [2:0] nf;
  logic [15:0] nmain;
  logic [7:0] fdac, pwr_att;
  logic [9:0] nref;
  logic [1:0] rsm, rsa, cp_sel, lock_sel, mdiv_sel;
  logic [13:0] naux;
  logic [5:0] pa_test;
  logic [3:0] word_ld;

  int tests = 0, fails = 0;
  int ldc [4] = '{0, 0, 0, 0};

  always #10 clk = ~clk;

  synth_prog_if dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb),
    .div_sync(div_sync), .fmod(fmod), .nf(nf), .nmain(nmain), .fdac(fdac),
    .speedup(speedup), .nref(nref), .rsm(rsm), .rsa(rsa), .naux(naux),
    .cp_sel(cp_sel), .lock_sel(lock_sel), .main_en(main_en), .aux_en(aux_en),
    .pwr_att(pwr_att), .mdiv_sel(mdiv_sel), .offset_en(offset_en), .tx_mode(tx_mode),
    .dig_mode(dig_mode), .txlo_buf_en(txlo_buf_en), .rclk_buf_en(rclk_buf_en),
    .pa_test(pa_test), .word_ld(word_ld));

  always @(negedge clk)
    for (int k = 0; k < 4; k++) if (word_ld[k]) ldc[k]++;

  localparam logic [23:0] VEC [6] = '{
    {2'b01, 10'd300, 2'b10, 2'b01, 8'd77},
    {2'b10, 14'd5000, 2'b01, 2'b11, 1'b1, 1'b0, 2'b11},
    {3'b110, 8'hA5, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 6'h2A},
    {3'b111, 21'h1FFFFF},
    {2'b01, 10'd1023, 2'b01, 2'b11, 8'd128},
    {2'b10, 14'd128, 2'b10, 2'b00, 1'b0, 1'b1, 2'b00}
  };

  // bench-side model of the group contents
  logic [9:0] e_nref = 10'd81;  logic [1:0] e_rsm = 0, e_rsa = 0;
  logic [7:0] e_tmp = 8'd80, e_fdac = 8'd80;
  logic [13:0] e_naux = 14'd458; logic [1:0] e_cp = 0, e_lock = 0;
  logic e_men = 0, e_aen = 0;
  logic [20:0] e_d = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [23:0] w);
    @(negedge clk); ser_stb = 1'b0;
    for (int i = 0; i < 24; i++) begin
      ser_dat = w[i]; wait_n(2);
      ser_clk = 1'b1; wait_n(2);
      ser_clk = 1'b0;
    end
    wait_n(1);
  endtask

  task automatic send_word(input logic [23:0] w);
    shift_bits(w);
    ser_stb = 1'b1;
    wait_n(5);
  endtask

  task automatic sync_pulse();
    @(negedge clk); div_sync = 1'b1;
    @(negedge clk); div_sync = 1'b0;
    wait_n(2);
  endtask

  task automatic check_groups(input string req);
    check(req, {22'd0, nref}, {22'd0, e_nref});
    check(req, {28'd0, rsm, rsa}, {28'd0, e_rsm, e_rsa});
    check(req, {24'd0, fdac}, {24'd0, e_fdac});
    check(req, {18'd0, naux}, {18'd0, e_naux});
    check(req, {26'd0, cp_sel, lock_sel, main_en, aux_en}, {26'd0, e_cp, e_lock, e_men, e_aen});
    check(req, {11'd0, pwr_att, mdiv_sel, offset_en, tx_mode, dig_mode, txlo_buf_en,
                rclk_buf_en, pa_test}, {11'd0, e_d});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c0 [4];
    wait_n(5); rst = 1'b0; wait_n(2);
    // R1 reset state
    check("R1 nmain", {16'd0, nmain}, 32'd1000);
    check("R1 fmod/nf", {28'd0, fmod, nf}, 32'd0);
    check("R1 speedup/ld", {27'd0, speedup, word_ld}, 32'd0);
    check_groups("R1");

    // R2 R4 R5 R7 R10 R12: table of words
    for (int v = 0; v < 6; v++) begin
      logic [23:0] w;
      int ty;
      w = VEC[v];
      c0 = ldc;
      ty = -1;
      if (w[23:22] == 2'b01) begin
        ty = 1; e_nref = w[21:12]; e_rsm = w[11:10]; e_rsa = w[9:8]; e_tmp = w[7:0];
      end else if (w[23:22] == 2'b10) begin
        ty = 2; e_naux = w[21:8]; e_cp = w[7:6]; e_lock = w[5:4]; e_men = w[3]; e_aen = w[2];
      end else if (w[23:21] == 3'b110) begin
        ty = 3; e_d = w[20:0];
      end
      send_word(w);
      check_groups("R5 R2 R7 group contents");
      for (int k = 0; k < 4; k++)
        check("R4 R10 R12 load pulse count", ldc[k] - c0[k], (k == ty) ? 1 : 0);
    end

    // R3: clocks while strobe high do not shift; a bare re-strobe reloads the C word
    c0 = ldc;
    for (int i = 0; i < 10; i++) begin
      ser_dat = ~ser_dat; wait_n(2); ser_clk = 1'b1; wait_n(2); ser_clk = 1'b0;
    end
    wait_n(2); ser_stb = 1'b0; wait_n(3); ser_stb = 1'b1; wait_n(5);
    check_groups("R3 held word reloaded");
    check("R3 R10 one C reload", ldc[2] - c0[2], 1);

    // R6 R8: A words pend until sync, newest replaces
    c0 = ldc;
    send_word({2'b00, 1'b1, 3'd5, 16'd2000, 2'b00});
    check("R6 pending not visible", {16'd0, nmain}, 32'd1000);
    send_word({2'b00, 1'b0, 3'd2, 16'd3000, 2'b11});
    check("R6 R8 still pending", {16'd0, nmain}, 32'd1000);
    check("R6 no A pulse yet", ldc[0] - c0[0], 0);
    sync_pulse();
    e_fdac = e_tmp;
    check("R8 latest word committed", {16'd0, nmain}, 32'd3000);
    check("R6 fmod/nf", {28'd0, fmod, nf}, {28'd0, 1'b0, 3'd2});
    check("R7 fdac with commit", {24'd0, fdac}, 32'd128);
    check("R9 speedup while strobe high", {31'd0, speedup}, 32'd1);
    check("R10 A commit pulse", ldc[0] - c0[0], 1);
    @(negedge clk); ser_stb = 1'b0; wait_n(3);
    check("R9 speedup cleared", {31'd0, speedup}, 32'd0);
    c0 = ldc;
    sync_pulse();
    check("R6 empty sync no change", {16'd0, nmain}, 32'd3000);
    check("R6 empty sync no pulse", ldc[0] - c0[0], 0);

    // R9: commit with strobe low gives no speed-up
    send_word({2'b00, 1'b0, 3'd1, 16'd4000, 2'b00});
    @(negedge clk); ser_stb = 1'b0; wait_n(3);
    sync_pulse();
    check("R9 commit strobe low nmain", {16'd0, nmain}, 32'd4000);
    check("R9 no speedup strobe low", {31'd0, speedup}, 32'd0);

    // R11: new A load and sync in the same cycle
    send_word({2'b00, 1'b1, 3'd7, 16'd5000, 2'b00});
    shift_bits({2'b00, 1'b0, 3'd3, 16'd6000, 2'b00});
    ser_stb = 1'b1;
    @(negedge clk); @(negedge clk); div_sync = 1'b1;
    @(negedge clk); div_sync = 1'b0;
    wait_n(2);
    check("R11 older word committed", {16'd0, nmain}, 32'd5000);
    check("R11 speedup strobe high", {31'd0, speedup}, 32'd1);
    sync_pulse();
    check("R11 newer word on next sync", {16'd0, nmain}, 32'd6000);
    check("R11 nf of newer word", {29'd0, nf}, 32'd3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule